// File: doc/BRIEF.md
# Password Memory Lock Controller

This block decides whether protected on-chip memory may be touched. A 128-bit password lives in nonvolatile locations outside the block and arrives on a flat input bus. Software loads a 128-bit key into the block as eight 16-bit register writes. It then reads each of the eight password words once, in any order. The block compares the key with the stored password on the final read, and its unlock state follows the result of that compare.

While the block is locked, it filters every access aimed at the three protected regions: the nonvolatile program/OTP region and two RAM blocks. Only code that itself executes from protected memory gets through. Debug-port accesses are denied. Code fetched from external memory is denied. Code running from unprotected internal memory is also denied. A denied read returns zero, and a denied write never reaches the memory.

A force-lock pulse returns the block to the locked state at any time. A password that is all ones marks an unprogrammed part, and such a part is always open. The block also drives a lock status bit, one open flag per region and a debug-open flag for the rest of the chip.

Top module: `mlc_lock_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the block is locked (secure_o = 1 unless the password is all ones) and all eight key words are zero.
- R2: A key write stores kw_data as key word kw_idx. Key word i is bits [16i+15:16i] of the 128-bit key and is compared against the same bits of pwd_nv.
- R3: Once all eight password word indices have been read through pr_en (any order, repeats count once), the block compares the key with the password. The compare uses only reads made since the last key write, force lock or compare. secure_o changes in the cycle after that final read: it goes to 0 on an exact match and to 1 otherwise.
- R4: A key write clears the read progress. A password read in the same cycle as a key write is not counted.
- R5: lock_req sets secure_o to 1 in the next cycle and clears the read progress. It takes priority over a compare in the same cycle, and the key words are kept.
- R6: When pwd_nv is all ones, secure_o is 0 in the same cycle, whatever the compare history and lock_req.
- R7: An access is granted when acc_region ≥ 3 (unprotected) or the block is unlocked. A protected access (region 0, 1 or 2) while locked is granted only for acc_src = 0 (code running from protected memory). It is denied for acc_src = 1 (unprotected internal code), 2 (external code) and 3 (debug port).
- R8: acc_rdata equals mem_rdata for a granted read (acc_valid=1, acc_we=0) and is zero otherwise; mem_re is high exactly for granted reads.
- R9: mem_we is high exactly for a granted write (acc_valid=1, acc_we=1); a denied write changes nothing.
- R10: pr_rdata returns password word pr_idx while pr_en=1 and the block is unlocked, and zero otherwise.
- R11: region_open[2:0] are all 1 and dbg_open is 1 exactly when secure_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kw_en | input | 1 | Key word write strobe |
| kw_idx | input | 3 | Key word index |
| kw_data | input | 16 | Key word data |
| pr_en | input | 1 | Password word read strobe |
| pr_idx | input | 3 | Password word index |
| pr_rdata | output | 16 | Password word read data (zero while locked) |
| lock_req | input | 1 | Force-lock pulse |
| pwd_nv | input | 128 | Stored password from nonvolatile locations |
| acc_valid | input | 1 | Memory access request |
| acc_src | input | 2 | Requester: 0 protected code, 1 unprotected internal code, 2 external code, 3 debug |
| acc_region | input | 2 | Target region: 0 program/OTP, 1 RAM A, 2 RAM B, 3 unprotected |
| acc_we | input | 1 | Access is a write |
| mem_rdata | input | 16 | Read data from memory |
| acc_rdata | output | 16 | Read data to requester |
| mem_re | output | 1 | Read enable to memory |
| mem_we | output | 1 | Write enable to memory |
| secure_o | output | 1 | 1 while locked |
| region_open | output | 3 | Per-region open flags |
| dbg_open | output | 1 | Debug access to protected memory allowed |

## Verification
The hardest state to reach from the ports is a compare that counts only part of the reads software made. The read progress can be reset by a key write, by a force lock, or by a read in the same cycle as a key write. It must also survive repeated reads of one index. The stimulus reaches these cases in three ways. It interrupts a read sequence with a key write after five reads. It issues a force lock one read before completion. It repeats an index so that seven distinct reads never trigger a compare. After each of these, the reference model's view of the progress shows whether the next single read unlocks the part or does nothing. A key that differs only in the top bit of the last word shows that every bit takes part in the compare.

// File: rtl/mlc_pkg.sv
package mlc_pkg;
  typedef enum logic [1:0] {
    SRC_SECURE = 2'd0,
    SRC_OPEN   = 2'd1,
    SRC_EXT    = 2'd2,
    SRC_DEBUG  = 2'd3
  } src_e;
endpackage

// File: rtl/mlc_key_bank.sv
module mlc_key_bank #(
  parameter int WORD_W = 16,
  parameter int NWORDS = 8,
  localparam int IDX_W = $clog2(NWORDS),
  localparam int KEY_W = WORD_W * NWORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [KEY_W-1:0]  pwd,
  output logic              match,
  output logic              blank
);
  logic [KEY_W-1:0] key_flat;

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    logic [WORD_W-1:0] word_q;
    logic              word_ce;

    assign word_ce = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_q <= '0;
      else if (word_ce) word_q <= wr_data;
    end

    assign key_flat[g*WORD_W +: WORD_W] = word_q;
  end

  assign match = (key_flat == pwd);
  assign blank = &pwd;
endmodule

// File: rtl/mlc_seq.sv
module mlc_seq #(
  parameter int NWORDS = 8,
  localparam int IDX_W = $clog2(NWORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_wr,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             force_lock,
  input  logic             match,
  output logic             unlocked
);
  logic [NWORDS-1:0] seen_q, seen_d, seen_hit;
  logic              unl_q, unl_d;

  always_comb begin
    seen_hit = seen_q | (NWORDS'(1) << rd_idx);
    seen_d   = seen_q;
    unl_d    = unl_q;
    if (force_lock) begin
      seen_d = '0;
      unl_d  = 1'b0;
    end else if (key_wr) begin
      seen_d = '0;
    end else if (rd_en) begin
      if (&seen_hit) begin
        seen_d = '0;
        unl_d  = match;
      end else begin
        seen_d = seen_hit;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
      unl_q  <= 1'b0;
    end else begin
      seen_q <= seen_d;
      unl_q  <= unl_d;
    end
  end

  assign unlocked = unl_q;
endmodule

// File: rtl/mlc_gate.sv
module mlc_gate
  import mlc_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int NREG   = 3,
  localparam int REG_W = $clog2(NREG + 1)
) (
  input  logic              secure,
  input  logic              acc_valid,
  input  logic [1:0]        acc_src,
  input  logic [REG_W-1:0]  acc_region,
  input  logic              acc_we,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [WORD_W-1:0] acc_rdata,
  output logic              mem_re,
  output logic              mem_we
);
  logic prot, allow;
  src_e src;

  always_comb begin
    src       = src_e'(acc_src);
    prot      = (32'(acc_region) < NREG);
    allow     = !prot || !secure || (src == SRC_SECURE);
    mem_re    = acc_valid && !acc_we && allow;
    mem_we    = acc_valid && acc_we && allow;
    acc_rdata = mem_re ? mem_rdata : '0;
  end
endmodule

// File: rtl/mlc_lock_ctrl.sv
module mlc_lock_ctrl #(
  parameter int WORD_W = 16,
  parameter int NWORDS = 8,
  parameter int NREG   = 3,
  localparam int IDX_W = $clog2(NWORDS),
  localparam int KEY_W = WORD_W * NWORDS,
  localparam int REG_W = $clog2(NREG + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kw_en,
  input  logic [IDX_W-1:0]  kw_idx,
  input  logic [WORD_W-1:0] kw_data,
  input  logic              pr_en,
  input  logic [IDX_W-1:0]  pr_idx,
  output logic [WORD_W-1:0] pr_rdata,
  input  logic              lock_req,
  input  logic [KEY_W-1:0]  pwd_nv,
  input  logic              acc_valid,
  input  logic [1:0]        acc_src,
  input  logic [REG_W-1:0]  acc_region,
  input  logic              acc_we,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [WORD_W-1:0] acc_rdata,
  output logic              mem_re,
  output logic              mem_we,
  output logic              secure_o,
  output logic [NREG-1:0]   region_open,
  output logic              dbg_open
);
  logic match, blank, unlocked;

  mlc_key_bank #(.WORD_W(WORD_W), .NWORDS(NWORDS)) u_keys (
    .clk(clk), .rst_n(rst_n), .wr_en(kw_en), .wr_idx(kw_idx),
    .wr_data(kw_data), .pwd(pwd_nv), .match(match), .blank(blank)
  );

  mlc_seq #(.NWORDS(NWORDS)) u_seq (
    .clk(clk), .rst_n(rst_n), .key_wr(kw_en), .rd_en(pr_en),
    .rd_idx(pr_idx), .force_lock(lock_req), .match(match),
    .unlocked(unlocked)
  );

  assign secure_o    = !(unlocked || blank);
  assign region_open = {NREG{!secure_o}};
  assign dbg_open    = !secure_o;
  assign pr_rdata    = (pr_en && !secure_o) ? pwd_nv[pr_idx*WORD_W +: WORD_W] : '0;

  mlc_gate #(.WORD_W(WORD_W), .NREG(NREG)) u_gate (
    .secure(secure_o), .acc_valid(acc_valid), .acc_src(acc_src),
    .acc_region(acc_region), .acc_we(acc_we), .mem_rdata(mem_rdata),
    .acc_rdata(acc_rdata), .mem_re(mem_re), .mem_we(mem_we)
  );
endmodule

// File: rtl/mlc_lock_chk.sv
module mlc_lock_chk #(
  parameter int WORD_W = 16,
  parameter int NWORDS = 8,
  parameter int NREG   = 3,
  localparam int IDX_W = $clog2(NWORDS),
  localparam int KEY_W = WORD_W * NWORDS,
  localparam int REG_W = $clog2(NREG + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pr_en,
  input logic              lock_req,
  input logic [KEY_W-1:0]  pwd_nv,
  input logic              acc_valid,
  input logic [1:0]        acc_src,
  input logic [REG_W-1:0]  acc_region,
  input logic              acc_we,
  input logic [WORD_W-1:0] acc_rdata,
  input logic              mem_we,
  input logic              secure_o
);
  logic prot;
  assign prot = (32'(acc_region) < NREG);

  // R5
  force_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_req && !(&pwd_nv)) |=> (secure_o || (&pwd_nv)));

  // R3
  unlock_by_compare_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(secure_o) && !(&pwd_nv)) |-> $past(pr_en));

  // R8
  denied_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_we && secure_o && prot && acc_src != 2'd0) |-> (acc_rdata == '0));

  // R9
  locked_write_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && secure_o && prot) |-> (acc_src == 2'd0));

  // R6
  blank_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&pwd_nv) |-> !secure_o);
endmodule

bind mlc_lock_ctrl mlc_lock_chk #(.WORD_W(WORD_W), .NWORDS(NWORDS), .NREG(NREG)) u_chk (.*);

// File: tb/sim_mlc_lock_ctrl.sv
module sim_mlc_lock_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic kw_en, pr_en, lock_req, acc_valid, acc_we;
  logic [2:0] kw_idx, pr_idx;
  logic [15:0] kw_data, mem_rdata, pr_rdata, acc_rdata;
  logic [127:0] pwd_nv;
  logic [1:0] acc_src, acc_region;
  logic mem_re, mem_we, secure_o, dbg_open;
  logic [2:0] region_open;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  mlc_lock_ctrl u0 (.*);

  // reference model
  logic [15:0] m_key [8];
  bit   [7:0]  m_seen;
  bit          m_unl;

  function automatic logic [127:0] m_keyflat();
    logic [127:0] k;
    for (int i = 0; i < 8; i++) k[16*i +: 16] = m_key[i];
    return k;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) m_key[i] <= '0;
      m_seen <= '0;
      m_unl  <= 1'b0;
    end else begin
      if (kw_en) m_key[kw_idx] <= kw_data;
      if (lock_req) begin
        m_seen <= '0; m_unl <= 1'b0;
      end else if (kw_en) begin
        m_seen <= '0;
      end else if (pr_en) begin
        bit [7:0] s;
        s = m_seen;
        s[pr_idx] = 1'b1;
        if (&s) begin
          m_seen <= '0;
          m_unl  <= (m_keyflat() == pwd_nv);
        end else m_seen <= s;
      end
    end
  end

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      bit sec, allow, ere, ewe;
      sec   = !(m_unl || (&pwd_nv));
      allow = (acc_region == 2'd3) || !sec || (acc_src == 2'd0);
      ere   = acc_valid && !acc_we && allow;
      ewe   = acc_valid && acc_we && allow;
      chk("R3 secure_o", secure_o, sec);
      chk("R11 region_open", region_open, sec ? 3'b000 : 3'b111);
      chk("R11 dbg_open", dbg_open, !sec);
      chk("R10 pr_rdata", pr_rdata, (pr_en && !sec) ? pwd_nv[16*pr_idx +: 16] : 16'h0);
      chk("R7 mem_re", mem_re, ere);
      chk("R8 acc_rdata", acc_rdata, ere ? mem_rdata : 16'h0);
      chk("R9 mem_we", mem_we, ewe);
    end
  end

  // stimulus helpers: each drives one cycle
  task automatic idle();
    @(negedge clk); #1;
    kw_en = 0; pr_en = 0; lock_req = 0; acc_valid = 0; acc_we = 0;
    kw_idx = 0; pr_idx = 0; kw_data = 0; acc_src = 0; acc_region = 0;
    mem_rdata = 16'hA5C3;
  endtask
  task automatic wr_key(input int i, input logic [15:0] d);
    idle(); kw_en = 1; kw_idx = 3'(i); kw_data = d;
  endtask
  task automatic rd_pw(input int i);
    idle(); pr_en = 1; pr_idx = 3'(i);
  endtask
  task automatic force_lock();
    idle(); lock_req = 1;
  endtask
  task automatic access(input int src, input int rg, input bit we);
    idle(); acc_valid = 1; acc_src = 2'(src); acc_region = 2'(rg); acc_we = we;
    mem_rdata = 16'h1000 + 16'(src * 4 + rg);
  endtask
  task automatic load_key(input logic [127:0] k);
    for (int i = 0; i < 8; i++) wr_key(i, k[16*i +: 16]);
  endtask
  task automatic read_all();
    for (int i = 7; i >= 0; i--) rd_pw((i * 3) % 8);
  endtask
  task automatic sweep_access();
    for (int s = 0; s < 4; s++)
      for (int r = 0; r < 4; r++) begin
        access(s, r, 1'b0);
        access(s, r, 1'b1);
      end
  endtask
  task automatic expect_secure(input bit exp, input string tag);
    @(negedge clk); #2;
    chk(tag, secure_o, exp);
  endtask

  localparam logic [127:0] PWD = 128'h3C5A_9E17_0F42_D8B6_7713_E2AC_51F0_9B6D;

  initial begin : watchdog
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    kw_en = 0; pr_en = 0; lock_req = 0; acc_valid = 0; acc_we = 0;
    kw_idx = 0; pr_idx = 0; kw_data = 0; acc_src = 0; acc_region = 0;
    mem_rdata = 0; pwd_nv = 128'h0;
    repeat (3) @(negedge clk);
    chk("R1 secure_o in reset", secure_o, 1'b1);
    rst_n = 1'b1;
    idle();
    expect_secure(1'b1, "R1 locked after reset");
    // R1: cleared key matches an all-zero password
    read_all(); idle();
    expect_secure(1'b0, "R1 zero key matches zero password");
    force_lock(); idle();
    expect_secure(1'b1, "R5 force lock");

    pwd_nv = PWD;
    sweep_access(); // R7 locked
    // R2: wrong key (words swapped) stays locked
    load_key({PWD[15:0], PWD[127:16]});
    read_all(); idle();
    expect_secure(1'b1, "R2 swapped words mismatch");
    load_key(PWD);
    for (int i = 0; i < 8; i++) rd_pw(i);
    idle();
    expect_secure(1'b0, "R3 matching key unlocks");
    sweep_access(); // R7 unlocked
    for (int i = 0; i < 8; i++) rd_pw(i); // R10 data visible
    // R3: mismatch by one bit relocks
    wr_key(7, PWD[127:112] ^ 16'h8000);
    read_all(); idle();
    expect_secure(1'b1, "R3 single-bit mismatch relocks");
    wr_key(7, PWD[127:112]);
    // R4: key write after five reads cancels progress
    for (int i = 0; i < 5; i++) rd_pw(i);
    wr_key(0, PWD[15:0]);
    for (int i = 5; i < 8; i++) rd_pw(i);
    idle();
    expect_secure(1'b1, "R4 key write cancels progress");
    // R4: read in same cycle as key write not counted
    for (int i = 1; i < 8; i++) rd_pw(i);
    wr_key(1, PWD[31:16]); pr_en = 1; pr_idx = 3'd0;
    idle();
    expect_secure(1'b1, "R4 simultaneous read ignored");
    // R3: repeats count once
    for (int i = 0; i < 7; i++) rd_pw(i);
    rd_pw(3); idle();
    expect_secure(1'b1, "R3 repeat not completing");
    rd_pw(7); idle();
    expect_secure(1'b0, "R3 completes on eighth index");
    // R5: force lock one read before completion, priority over compare
    force_lock();
    for (int i = 0; i < 7; i++) rd_pw(i);
    force_lock(); pr_en = 1; pr_idx = 3'd7;
    idle();
    expect_secure(1'b1, "R5 force lock beats compare");
    rd_pw(7); idle();
    expect_secure(1'b1, "R5 progress cleared");
    read_all(); idle();
    expect_secure(1'b0, "R5 key kept after force lock");
    // R6: blank password
    force_lock(); idle();
    pwd_nv = '1;
    idle();
    expect_secure(1'b0, "R6 blank password open");
    force_lock(); idle();
    expect_secure(1'b0, "R6 force lock no effect when blank");
    sweep_access();
    pwd_nv = PWD;
    idle();
    expect_secure(1'b1, "R6 leaving blank relocks");
    sweep_access(); // R8 R9 denied paths
    repeat (3) idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule